// File: doc/BRIEF.md
# Write-Busy Status Read Path

This block is the read side of a byte-wide nonvolatile memory port. A host reads by holding write enable high and pulling chip enable and output enable low. After a fixed access delay, counted in clock cycles, the block drives the data bus with the stored byte. When no read is requested, it releases the bus at once. The bus is modelled as a data vector plus an output-enable flag, and the data vector reads zero whenever the bus is released.

A self-timed program cycle may be running. While it runs, the block replaces the array data with completion status, so the host can poll without a separate status register. There are two status indications:

- **Polling bit.** A read of the location written last returns the inverted top bit of the byte written there.
- **Toggle bit.** The next bit down flips on every read that starts during the busy period.

When the program cycle ends, the status indications stop and reads return the stored bytes again.

Top module: `wip_read_port`

## Requirements
- R1: A read is requested when `we_n` is 1 and `ce_n` and `oe_n` are both 0. `bus_oe` is 0 after reset.
- R2: When `ce_n` is 1, `oe_n` is 1 or `we_n` is 0, `bus_oe` is 0 in the same cycle and `bus_dout` is all zeros.
- R3: The request may be held from a point between clock edges. `bus_oe` stays 0 until `ACC_CYC` rising edges have passed with the request held. It is 1 from that point until the request is withdrawn.
- R4: While `busy` is 0, a driven bus carries `array_rdata` unchanged on all bits.
- R5: While `busy` is 1 and `addr` equals `last_addr`, bit 7 of a driven bus is the inverse of bit 7 of `last_data`.
- R6: While `busy` is 1, bit 6 of a driven bus takes opposite values on two successive reads.
- R7: A read that starts while `busy` is 0 does not advance the bit 6 toggle state. Two busy reads separated only by idle reads still return opposite bit 6 values.
- R8: While `busy` is 1, bits 5 to 0 carry `array_rdata`. Bit 7 also carries `array_rdata` when `addr` differs from `last_addr`.
- R9: In the first read started after `busy` falls, all eight bits return `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Read address |
| array_rdata | input | 8 | Stored byte at `addr` |
| busy | input | 1 | Program cycle in progress |
| last_addr | input | 13 | Address of the last written byte |
| last_data | input | 8 | Value of the last written byte |
| bus_dout | output | 8 | Bus data, zero when not driven |
| bus_oe | output | 1 | Bus output enable |

## Verification
Data appears exactly `ACC_CYC` rising edges after the read strobes are applied. The bench applies the strobes on a falling edge and samples `bus_oe` on each of the following falling edges. It expects 0 for the first `ACC_CYC-1` samples and 1 with valid data on the `ACC_CYC`-th sample.

The bus release has no latency. The bench checks it one nanosecond after raising a strobe, well before the next edge.

The toggle flop flips at the first edge of a busy read. Its new value is therefore already visible when the data becomes valid. The bench compares bit 6 between reads rather than against an absolute value.

// File: rtl/wip_rd_pkg.sv
package wip_rd_pkg;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
   } strobe_t;

endpackage

// File: rtl/wip_rd_ctrl.sv
module wip_rd_ctrl
   import wip_rd_pkg::*;
#(
   parameter int ACC_CYC = 3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  strobe_t stb,
   output logic    rd_req,
   output logic    rd_start,
   output logic    drive
);
   localparam int CW = $clog2(ACC_CYC + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(ACC_CYC);

   if (ACC_CYC < 1) begin : g_bad_acc
      $error("ACC_CYC must be at least 1");
   end

   logic          rd_q;
   logic [CW-1:0] cnt;

   assign rd_req   = !stb.ce_n && !stb.oe_n && stb.we_n;
   assign rd_start = rd_req && !rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         cnt  <= '0;
      end else begin
         rd_q <= rd_req;
         if (!rd_req)
            cnt <= '0;
         else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
      end
   end

   assign drive = rd_req && (cnt == CNT_MAX);

   // R3: no data in the cycle a read begins
   a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> !drive);

   // R3: once driving, stays driving while the request holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      drive |=> (!rd_req || drive));

endmodule

// File: rtl/wip_toggle.sv
module wip_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_start,
   input  logic busy,
   output logic tgl
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         tgl <= 1'b0;
      else if (rd_start && busy)
         tgl <= !tgl;
   end

   // R6: a busy read start flips the state
   a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && busy) |=> (tgl != $past(tgl)));

   // R7: no other event changes it
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_start && busy) |=> $stable(tgl));

endmodule

// File: rtl/wip_status_mux.sv
module wip_status_mux #(
   parameter int DW       = 8,
   parameter int AW       = 13,
   parameter int POLL_BIT = DW - 1,
   parameter int TGL_BIT  = DW - 2
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] last_addr,
   input  logic [DW-1:0] last_data,
   input  logic [DW-1:0] arr,
   input  logic          busy,
   input  logic          tgl,
   input  logic          drive,
   output logic [DW-1:0] dout
);
   logic          hit;
   logic [DW-1:0] st;

   assign hit = (addr == last_addr);

   for (genvar i = 0; i < DW; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign st[i] = hit ? !last_data[i] : arr[i];
      end else if (i == TGL_BIT) begin : g_tgl
         assign st[i] = tgl;
      end else begin : g_pass
         assign st[i] = arr[i];
      end
   end

   always_comb begin
      if (!drive)
         dout = '0;
      else if (busy)
         dout = st;
      else
         dout = arr;
   end

endmodule

// File: rtl/wip_read_port.sv
module wip_read_port
   import wip_rd_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 13,
   parameter int ACC_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] array_rdata,
   input  logic          busy,
   input  logic [AW-1:0] last_addr,
   input  logic [DW-1:0] last_data,
   output logic [DW-1:0] bus_dout,
   output logic          bus_oe
);
   localparam int POLL_BIT = DW - 1;
   localparam int TGL_BIT  = DW - 2;

   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end

   strobe_t stb;
   logic    rd_req, rd_start, drive, tgl;

   assign stb = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

   wip_rd_ctrl #(.ACC_CYC(ACC_CYC)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (stb),
      .rd_req   (rd_req),
      .rd_start (rd_start),
      .drive    (drive)
   );

   wip_toggle u_tgl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_start (rd_start),
      .busy     (busy),
      .tgl      (tgl)
   );

   wip_status_mux #(
      .DW(DW), .AW(AW), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)
   ) u_mux (
      .addr      (addr),
      .last_addr (last_addr),
      .last_data (last_data),
      .arr       (array_rdata),
      .busy      (busy),
      .tgl       (tgl),
      .drive     (drive),
      .dout      (bus_dout)
   );

   assign bus_oe = drive;

   // R2: strobes inactive means a released, zero bus
   a_r2_float: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n || !we_n) |-> (!bus_oe && bus_dout == '0));

   // R4: idle reads pass array data
   a_r4_true: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !busy) |-> (bus_dout == array_rdata));

   // R5: polling bit on the last written location
   a_r5_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && busy && addr == last_addr) |->
         (bus_dout[POLL_BIT] == !last_data[POLL_BIT]));

   // R8: low bits carry array data while busy
   a_r8_low: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && busy) |->
         (bus_dout[TGL_BIT-1:0] == array_rdata[TGL_BIT-1:0]));

endmodule

// File: tb/wip_read_port_bench.sv
module wip_read_port_bench;
   localparam int DW  = 8;
   localparam int AW  = 13;
   localparam int ACC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] array_rdata;
   logic          busy = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic [DW-1:0] last_data = '0;
   logic [DW-1:0] bus_dout;
   logic          bus_oe;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   // array contents computed from the address
   assign array_rdata = addr[7:0] ^ {3'b010, addr[12:8]};

   wip_read_port #(.DW(DW), .AW(AW), .ACC_CYC(ACC)) u_wip_read_port (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .array_rdata(array_rdata), .busy(busy),
      .last_addr(last_addr), .last_data(last_data),
      .bus_dout(bus_dout), .bus_oe(bus_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // full read: returns data sampled at the first driven cycle
   task automatic do_read(input logic [AW-1:0] a, input bit chk_tim, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      #0.5;
      if (chk_tim) chk(bus_oe == 1'b0, "R3 early", bus_oe, 0);
      for (int k = 1; k < ACC; k++) begin
         @(negedge clk);
         if (chk_tim) chk(bus_oe == 1'b0, "R3 early", bus_oe, 0);
      end
      @(negedge clk);
      chk(bus_oe == 1'b1, "R1/R3 driven", bus_oe, 1);
      d = bus_dout;
      @(negedge clk);
      if (chk_tim) chk(bus_oe == 1'b1 && bus_dout == d, "R3 hold", bus_dout, d);
      ce_n = 1'b1; oe_n = 1'b1;
      #1;
      if (chk_tim) chk(bus_oe == 1'b0 && bus_dout == '0, "R2 release", bus_dout, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] d, d2;
      logic          b6;
      repeat (3) @(negedge clk);
      chk(bus_oe == 1'b0 && bus_dout == '0, "R1 reset", bus_oe, 0);
      rst_n = 1'b1;

      // R2: write enable low blocks the read
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      repeat (ACC + 2) begin
         @(negedge clk);
         chk(bus_oe == 1'b0 && bus_dout == '0, "R2 we_n low", bus_oe, 0);
      end
      // R2: output enable high blocks the read
      we_n = 1'b1; oe_n = 1'b1;
      repeat (ACC + 2) begin
         @(negedge clk);
         chk(bus_oe == 1'b0 && bus_dout == '0, "R2 oe_n high", bus_oe, 0);
      end
      ce_n = 1'b1;

      // R4: idle sweep
      for (int a = 0; a < 1024; a++) begin
         do_read(AW'(a * 8 + (a % 8)), (a < 8), d);
         chk(d == array_rdata, "R4 idle data", d, array_rdata);
      end

      // busy phase
      busy = 1'b1; last_addr = 13'h0155; last_data = 8'hC3;
      do_read(last_addr, 1'b1, d);
      chk(d[7] == 1'b0, "R5 poll bit", d[7], 0);
      chk(d[5:0] == array_rdata[5:0], "R8 low bits", d[5:0], array_rdata[5:0]);
      b6 = d[6];
      for (int i = 0; i < 200; i++) begin
         logic [AW-1:0] a;
         a = (i % 2 == 0) ? last_addr : AW'(i * 37 + 3);
         do_read(a, 1'b0, d2);
         chk(d2[6] == !b6, "R6 toggle", d2[6], !b6);
         b6 = d2[6];
         chk(d2[5:0] == array_rdata[5:0], "R8 low bits", d2[5:0], array_rdata[5:0]);
         if (a == last_addr)
            chk(d2[7] == 1'b0, "R5 poll bit", d2[7], 0);
         else
            chk(d2[7] == array_rdata[7], "R8 other bit7", d2[7], array_rdata[7]);
      end
      last_data = 8'h3C;
      do_read(last_addr, 1'b0, d);
      chk(d[7] == 1'b1, "R5 poll bit inverse", d[7], 1);
      chk(d[6] == !b6, "R6 toggle", d[6], !b6);
      b6 = d[6];

      // R7: idle reads between busy reads do not advance the toggle
      busy = 1'b0;
      do_read(13'h0040, 1'b0, d);
      do_read(13'h1FFF, 1'b0, d);
      busy = 1'b1;
      do_read(13'h0022, 1'b0, d);
      chk(d[6] == !b6, "R7 idle no advance", d[6], !b6);

      // R9: first read after completion is true data
      busy = 1'b0;
      do_read(last_addr, 1'b1, d);
      chk(d == array_rdata, "R9 true data", d, array_rdata);
      do_read(13'h0A0A, 1'b0, d);
      chk(d == array_rdata, "R9 true data", d, array_rdata);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule